// File: doc/BRIEF.md
# HDLC Transmit Abort and Idle Controller

This block drives the serial output of an HDLC transmitter. It holds the next payload byte from the host in a one-byte holding register. It shifts each frame out as an opening flag, the payload, a 16-bit frame check and a closing flag, and it inserts a zero after every run of five ones inside the payload and the check field. One bit leaves the block on each cycle where the bit-clock enable is high. When no frame is active, the line carries back-to-back flags.

The host can stop a frame at any time by setting the abort bit. The block first finishes the byte it is shifting, then sends fill bits whose polarity the host selects. The block also reacts to a starved holding register (underrun) in one of two ways. With automatic end of frame enabled, the underrun closes the frame cleanly. Otherwise the block raises a sticky underrun flag and sets the abort bit itself. It keeps sending fill until the host clears that bit.

Top module: `hdlc_tx_ctrl`

## Requirements
- R1: After reset, `txd` is 1 and `buf_full`, `abort_bit` and `underrun` are all 0.
- R2: With no frame pending and no abort, the line repeats the flag pattern 0x7E, sent least significant bit first.
- R3: A byte written while the line is idle makes the block send exactly one opening flag, then the payload bytes least significant bit first.
- R4: A 0 is inserted after any five consecutive 1s in the payload and in the frame check field. No zero is ever inserted in flags or fill.
- R5: When the holding register is empty at a payload byte boundary and `aeof_en` is 1, the block sends the complement of a CRC-16 and then a closing flag 0x7E. The CRC uses polynomial 0x1021, processed least significant bit first (reflected constant 0x8408), with preset 0xFFFF, and is sent low-order bit first. Neither `underrun` nor `abort_bit` changes.
- R6: Setting the abort bit during a payload byte lets that byte finish in full before any fill bit appears.
- R7: Fill bits are all 1 when `fill_zero` is 0 and all 0 when `fill_zero` is 1.
- R8: If the abort bit is set and cleared again one bit period later, exactly eight fill bits are sent and flags follow.
- R9: An underrun with `aeof_en` = 0 sets `underrun` and `abort_bit`. Fill then continues for at least eight bits and for as long as `abort_bit` stays 1. Only a host write clears `abort_bit`, and flags resume after the current fill byte.
- R10: `underrun` stays set until a one-cycle pulse on `underrun_clr`, which clears it.
- R11: A pulse on `data_wr` sets `buf_full`. `buf_full` drops when the byte is taken into the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One serial bit is produced on each cycle where this is high |
| data_wr | input | 1 | Host strobe loading `data_in` into the holding register |
| data_in | input | 8 | Host payload byte |
| buf_full | output | 1 | Holding register holds a byte not yet taken |
| abort_wr | input | 1 | Host strobe writing `abort_wdata` into the abort bit |
| abort_wdata | input | 1 | Value written to the abort bit |
| abort_bit | output | 1 | Abort control/status bit |
| fill_zero | input | 1 | Fill polarity: 0 sends ones, 1 sends zeros |
| aeof_en | input | 1 | Treat underrun as end of frame |
| underrun_clr | input | 1 | Write-one-to-clear pulse for `underrun` |
| underrun | output | 1 | Sticky underrun status |
| txd | output | 1 | Serial transmit bit |

## Verification
Properties check on every cycle that the underrun flag and the abort bit never drop without a host action. They also check that an underrun always comes with the abort bit, that a zero follows every five-ones run, and that the holding register's full flag follows writes and takes. Only the scenarios can show the bit-exact stream: the opening and closing flags, the CRC value, byte completion before fill, the exact eight-bit fill after a short abort pulse, and the return to flags after the host clears the abort bit.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;
    localparam int          DATA_W   = 8;
    localparam int          FCS_W    = 16;
    localparam int          RUN_LEN  = 5;
    localparam int          CNT_W    = $clog2(FCS_W + 1);
    localparam int          ONES_W   = $clog2(RUN_LEN + 1);
    localparam logic [DATA_W-1:0] FLAG_BYTE = 8'h7E;
    localparam logic [FCS_W-1:0]  CRC_POLY  = 16'h8408;
    localparam logic [FCS_W-1:0]  CRC_INIT  = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE,
        ST_FILL
    } tx_unit_e;

    typedef struct packed {
        tx_unit_e            state;
        logic [FCS_W-1:0]    sh;
        logic [CNT_W-1:0]    cnt;
        logic [ONES_W-1:0]   ones;
        logic [FCS_W-1:0]    crc;
        logic                txd;
        logic                abort;
        logic                pend;
        logic                underrun;
    } tx_regs_t;

    function automatic logic [FCS_W-1:0] crc_step(input logic [FCS_W-1:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/hdlc_tx_hold.sv
`timescale 1ns/1ps
module hdlc_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic [W-1:0] rdata,
    output logic         full
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) hold_d.full = 1'b0;
        if (wr) begin
            hold_d.full = 1'b1;
            hold_d.data = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign rdata = hold_q.data;
    assign full  = hold_q.full;

    AST_HOLD_SET:  assert property (@(posedge clk) disable iff (!rst_n) wr |=> full);               // R11
    AST_HOLD_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (take && !wr) |=> !full);   // R11
endmodule

// File: rtl/hdlc_tx_patterns.sv
`timescale 1ns/1ps
module hdlc_tx_patterns
    import hdlc_tx_pkg::*;
(
    input  logic [FCS_W-1:0] crc_q,
    input  logic             fill_zero,
    output logic [FCS_W-1:0] flag_pat,
    output logic [FCS_W-1:0] fill_pat,
    output logic [FCS_W-1:0] fcs_pat
);
    localparam int PAD_W = FCS_W - DATA_W;

    assign flag_pat = {{PAD_W{1'b0}}, FLAG_BYTE};
    assign fill_pat = {{PAD_W{1'b0}}, {DATA_W{~fill_zero}}};
    assign fcs_pat  = ~crc_q;
endmodule

// File: rtl/hdlc_tx_ctrl.sv
`timescale 1ns/1ps
module hdlc_tx_ctrl
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    output logic              buf_full,
    input  logic              abort_wr,
    input  logic              abort_wdata,
    output logic              abort_bit,
    input  logic              fill_zero,
    input  logic              aeof_en,
    input  logic              underrun_clr,
    output logic              underrun,
    output logic              txd
);
    tx_regs_t          d, q;
    tx_unit_e          nxt;
    logic              take;
    logic              abort_go;
    logic              tx_bit;
    logic [FCS_W-1:0]  sh_cur;
    logic [CNT_W-1:0]  cnt_cur;
    logic [DATA_W-1:0] hold_data;
    logic [FCS_W-1:0]  flag_pat, fill_pat, fcs_pat;

    hdlc_tx_hold #(.W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (data_wr),
        .wdata (data_in),
        .take  (take),
        .rdata (hold_data),
        .full  (buf_full)
    );

    hdlc_tx_patterns u_pat (
        .crc_q     (q.crc),
        .fill_zero (fill_zero),
        .flag_pat  (flag_pat),
        .fill_pat  (fill_pat),
        .fcs_pat   (fcs_pat)
    );

    always_comb begin
        d        = q;
        take     = 1'b0;
        nxt      = q.state;
        sh_cur   = q.sh;
        cnt_cur  = q.cnt;
        tx_bit   = 1'b1;
        abort_go = q.abort | q.pend;

        if (abort_wr) begin
            d.abort = abort_wdata;
            if (abort_wdata) d.pend = 1'b1;
        end
        if (underrun_clr) d.underrun = 1'b0;

        if (bit_en) begin
            if (q.ones == ONES_W'(RUN_LEN)) begin
                // inserted zero; shifter holds still
                d.txd  = 1'b0;
                d.ones = '0;
            end else begin
                if (q.cnt == '0) begin
                    unique case (q.state)
                        ST_DATA: begin
                            if (abort_go)      nxt = ST_FILL;
                            else if (buf_full) nxt = ST_DATA;
                            else if (aeof_en)  nxt = ST_FCS;
                            else begin
                                nxt        = ST_FILL;
                                d.underrun = 1'b1;
                                d.abort    = 1'b1;
                            end
                        end
                        ST_FCS:  nxt = abort_go ? ST_FILL : ST_CLOSE;
                        ST_OPEN: nxt = abort_go ? ST_FILL : ST_DATA;
                        default: nxt = abort_go ? ST_FILL : (buf_full ? ST_OPEN : ST_IDLE);
                    endcase
                    d.state = nxt;
                    unique case (nxt)
                        ST_DATA: begin
                            sh_cur  = FCS_W'(hold_data);
                            cnt_cur = CNT_W'(DATA_W);
                            take    = 1'b1;
                        end
                        ST_FCS: begin
                            sh_cur  = fcs_pat;
                            cnt_cur = CNT_W'(FCS_W);
                        end
                        ST_FILL: begin
                            sh_cur  = fill_pat;
                            cnt_cur = CNT_W'(DATA_W);
                            d.pend  = abort_wr & abort_wdata;
                        end
                        ST_OPEN: begin
                            sh_cur  = flag_pat;
                            cnt_cur = CNT_W'(DATA_W);
                            d.crc   = CRC_INIT;
                        end
                        default: begin
                            sh_cur  = flag_pat;
                            cnt_cur = CNT_W'(DATA_W);
                        end
                    endcase
                end
                tx_bit = sh_cur[0];
                d.txd  = tx_bit;
                d.sh   = sh_cur >> 1;
                d.cnt  = cnt_cur - 1'b1;
                if (nxt == ST_DATA || nxt == ST_FCS)
                    d.ones = tx_bit ? ONES_W'(q.ones + 1'b1) : '0;
                else
                    d.ones = '0;
                if (nxt == ST_DATA) d.crc = crc_step(q.crc, tx_bit);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.crc      <= CRC_INIT;
            q.txd      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd       = q.txd;
    assign abort_bit = q.abort;
    assign underrun  = q.underrun;

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !underrun_clr) |=> underrun);                                   // R10
    AST_ABORT_HELD:      assert property (@(posedge clk) disable iff (!rst_n)
        (abort_bit && !abort_wr) |=> abort_bit);                                     // R9
    AST_UNDERRUN_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> abort_bit);                                              // R9
    AST_ZERO_AFTER_RUN:  assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && q.ones == ONES_W'(RUN_LEN)) |=> !txd);                           // R4
endmodule

// File: tb/hdlc_tx_ctrl_test.sv
`timescale 1ns/1ps
module hdlc_tx_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_in = '0;
    logic       buf_full;
    logic       abort_wr = 1'b0;
    logic       abort_wdata = 1'b0;
    logic       abort_bit;
    logic       fill_zero = 1'b0;
    logic       aeof_en = 1'b0;
    logic       underrun_clr = 1'b0;
    logic       underrun;
    logic       txd;

    int    checks = 0;
    int    errors = 0;
    int    pending = 0;
    int    bitno = 0;
    int    ph = 0;
    int    ones_run = 0;
    bit    ticks_on = 1'b0;
    logic  exp_bits[$];
    string exp_tags[$];
    logic  log_bits [0:1023];

    hdlc_tx_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .data_wr(data_wr), .data_in(data_in), .buf_full(buf_full),
        .abort_wr(abort_wr), .abort_wdata(abort_wdata), .abort_bit(abort_bit),
        .fill_zero(fill_zero), .aeof_en(aeof_en),
        .underrun_clr(underrun_clr), .underrun(underrun), .txd(txd)
    );

    always #2.5 clk = ~clk;

    // bit enable: one cycle in four
    initial begin
        forever begin
            @(negedge clk);
            if (ticks_on) begin
                ph = (ph + 1) % 4;
                bit_en = (ph == 0);
            end else begin
                ph = 0;
                bit_en = 1'b0;
            end
        end
    end

    // monitor: pops the scoreboard on every serial bit
    initial begin
        forever begin
            @(posedge clk);
            if (bit_en && rst_n) begin
                #1;
                if (bitno < 1024) log_bits[bitno] = txd;
                bitno++;
                if (pending > 0) begin
                    logic  e;
                    string t;
                    e = exp_bits.pop_front();
                    t = exp_tags.pop_front();
                    pending--;
                    checks++;
                    if (txd !== e) begin
                        errors++;
                        $display("FAIL %s bit %0d: txd=%b expected %b", t, bitno - 1, txd, e);
                    end
                end
            end
        end
    end

    initial begin
        #(150000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic push_bit(input logic b, input string tag);
        exp_bits.push_back(b);
        exp_tags.push_back(tag);
        pending++;
    endtask

    task automatic push_unit(input logic [15:0] v, input int n, input string tag);
        for (int i = 0; i < n; i++) push_bit(v[i], tag);
    endtask

    task automatic push_stuffed(input logic b, input string tag);
        push_bit(b, tag);
        if (b) begin
            ones_run++;
            if (ones_run == 5) begin
                push_bit(1'b0, "R4");
                ones_run = 0;
            end
        end else begin
            ones_run = 0;
        end
    endtask

    function automatic logic [15:0] crc_model(input logic [15:0] c, input logic b);
        logic [15:0] r;
        r = c >> 1;
        if (c[0] ^ b) r = r ^ 16'h8408;
        return r;
    endfunction

    task automatic push_frame(input logic [7:0] bytes [3]);
        logic [15:0] crc;
        crc = 16'hFFFF;
        ones_run = 0;
        push_unit(16'h007E, 8, "R3");
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 8; i++) begin
                push_stuffed(bytes[k][i], "R4");
                crc = crc_model(crc, bytes[k][i]);
            end
        end
        crc = ~crc;
        for (int i = 0; i < 16; i++) push_stuffed(crc[i], "R5");
        ones_run = 0;
        push_unit(16'h007E, 8, "R5");
    endtask

    task automatic do_reset();
        ticks_on = 1'b0;
        rst_n = 1'b0;
        data_wr = 1'b0; abort_wr = 1'b0; underrun_clr = 1'b0;
        exp_bits.delete();
        exp_tags.delete();
        pending = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bitno = 0;
    endtask

    task automatic host_write(input logic [7:0] v);
        data_in = v; data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic host_abort(input logic v);
        abort_wdata = v; abort_wr = 1'b1;
        @(negedge clk);
        abort_wr = 1'b0;
    endtask

    task automatic wait_bits(input int n);
        int t;
        t = bitno + n;
        while (bitno < t) @(negedge clk);
    endtask

    task automatic wait_drained();
        @(negedge clk);
        while (pending > 0) @(negedge clk);
    endtask

    task automatic wait_taken();
        while (buf_full) @(negedge clk);
    endtask

    initial begin
        logic [7:0] frm [3];
        int b;
        int f;

        // S1/S2: reset values, then idle flags
        do_reset();
        chk("R1 txd", 16'(txd), 16'd1);
        chk("R1 buf_full", 16'(buf_full), 16'd0);
        chk("R1 abort_bit", 16'(abort_bit), 16'd0);
        chk("R1 underrun", 16'(underrun), 16'd0);
        push_unit(16'h007E, 8, "R2");
        push_unit(16'h007E, 8, "R2");
        ticks_on = 1'b1;
        wait_drained();

        // S3: frame closed by automatic end of frame, with stuffing
        do_reset();
        aeof_en = 1'b1; fill_zero = 1'b0;
        frm[0] = 8'hFF; frm[1] = 8'h7E; frm[2] = 8'h3F;
        host_write(frm[0]);
        chk("R11 full after write", 16'(buf_full), 16'd1);
        push_frame(frm);
        ticks_on = 1'b1;
        for (int k = 1; k < 3; k++) begin
            wait_taken();
            host_write(frm[k]);
        end
        wait_drained();
        chk("R5 underrun untouched", 16'(underrun), 16'd0);
        chk("R5 abort untouched", 16'(abort_bit), 16'd0);
        chk("R11 empty after take", 16'(buf_full), 16'd0);

        // S4: underrun without auto end, fill of ones until cleared
        do_reset();
        aeof_en = 1'b0; fill_zero = 1'b0;
        host_write(8'h55);
        push_unit(16'h007E, 8, "R3");
        push_unit(16'h0055, 8, "R3");
        push_unit(16'hFFFF, 16, "R7");
        ticks_on = 1'b1;
        wait_drained();
        chk("R9 underrun set", 16'(underrun), 16'd1);
        chk("R9 abort set by block", 16'(abort_bit), 16'd1);
        wait_bits(8);
        chk("R9 abort still held", 16'(abort_bit), 16'd1);
        b = bitno;
        host_abort(1'b0);
        f = ((b + 7) / 8) * 8;
        wait_bits(f + 9 - bitno);
        for (int i = 16; i < f; i++) chk("R7 fill ones", 16'(log_bits[i]), 16'd1);
        for (int i = 0; i < 8; i++)
            chk("R9 flag after clear", 16'(log_bits[f + i]), 16'((8'h7E >> i) & 1));
        chk("R10 sticky", 16'(underrun), 16'd1);
        underrun_clr = 1'b1;
        @(negedge clk);
        underrun_clr = 1'b0;
        chk("R10 cleared", 16'(underrun), 16'd0);

        // S5: one-bit abort pulse mid-frame, zero fill
        do_reset();
        aeof_en = 1'b1; fill_zero = 1'b1;
        host_write(8'h55);
        push_unit(16'h007E, 8, "R3");
        push_unit(16'h0055, 8, "R3");
        push_unit(16'h00A5, 8, "R6");
        push_unit(16'h0000, 8, "R8");
        push_unit(16'h007E, 8, "R8");
        push_unit(16'h007E, 8, "R2");
        ticks_on = 1'b1;
        wait_taken();
        host_write(8'hA5);
        wait_taken();
        wait_bits(2);
        host_abort(1'b1);
        repeat (3) @(negedge clk);
        host_abort(1'b0);
        wait_drained();
        chk("R8 abort cleared", 16'(abort_bit), 16'd0);
        chk("R6 no underrun", 16'(underrun), 16'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule